// File: doc/BRIEF.md
# Row/Column Parity Grid Codec

This block protects a data word by placing its bits on a square grid and keeping one even-parity bit for each row, one for each column, and one bit over the whole codeword. The encoder is purely combinational. It takes a word of `SIDE*SIDE` bits and returns the row, column and overall check bits. These are stored beside the data.

On the read side, the decoder takes the stored data and the stored check bits and recomputes every parity. It compares the results with the stored checks and sorts the failure pattern into four cases:
- clean;
- a single flipped data bit, which it repairs by inverting the bit where the failing row and the failing column cross;
- a single flipped check bit, which needs no repair of the data;
- an uncorrectable pattern, in which the received data is passed out untouched.

A build option places a register stage after the decoder. This adds one cycle of latency and a valid output.

Top module: `parity_grid_codec`

## Requirements
- R1: `enc_row[r]` is the XOR of data bits `r*SIDE + c` for every column `c`, so that data bit `r*SIDE + c` sits at row `r`, column `c`.
- R2: `enc_col[c]` is the XOR of data bits `r*SIDE + c` for every row `r`.
- R3: `enc_all` makes the XOR of all data, row, column and overall bits zero; it equals the XOR of all data bits.
- R4: A codeword received without error leaves the decoded data equal to the received data, with both flags low.
- R5: A single inverted data bit is restored in the decoded data and `dec_corrected` is raised, with `dec_uncorrectable` low.
- R6: A single inverted row, column or overall check bit leaves the decoded data equal to the original data and raises `dec_corrected`.
- R7: Any two inverted bits anywhere in the codeword raise `dec_uncorrectable`, keep `dec_corrected` low and pass the received data out unchanged.
- R8: `dec_corrected` and `dec_uncorrectable` are never high together.
- R9: With `OUT_REG=1` (the default), `dec_out_valid` and the decoded results appear exactly one clock edge after `dec_in_valid` is sampled high. `dec_out_valid` is low while `rst` is high and in every cycle that does not follow an accepted input. With `OUT_REG=0` the results are combinational and `dec_out_valid` follows `dec_in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| enc_data | input | SIDE*SIDE | Word to encode |
| enc_row | output | SIDE | Row parity bits of `enc_data` |
| enc_col | output | SIDE | Column parity bits of `enc_data` |
| enc_all | output | 1 | Overall parity bit of `enc_data` |
| dec_in_valid | input | 1 | Received codeword present |
| dec_data | input | SIDE*SIDE | Received data bits |
| dec_row | input | SIDE | Received row check bits |
| dec_col | input | SIDE | Received column check bits |
| dec_all | input | 1 | Received overall check bit |
| dec_out_valid | output | 1 | Decoded results valid |
| dec_out_data | output | SIDE*SIDE | Decoded (possibly repaired) data |
| dec_corrected | output | 1 | A single-bit error was handled |
| dec_uncorrectable | output | 1 | Error pattern cannot be repaired |

## Verification
The encoder outputs are combinational, so they are sampled one time unit after `enc_data` changes, with no clock involved. Each received codeword is driven on a falling edge, and its expected result is queued at that moment. Under the default build, the decoded data and flags are due at the next rising edge. A monitor therefore compares them on the following falling edge, whenever `dec_out_valid` is high.

A probe checks `dec_out_valid` one time unit after a lone input is driven and expects it still low, which shows the result is not present early. Any valid output that arrives with no queued expectation counts as a timing failure.

// File: rtl/pgrid_pkg.sv
package pgrid_pkg;

    // Outcome of decoding one received codeword
    typedef enum logic [1:0] {
        DS_CLEAN     = 2'd0,
        DS_FIX_DATA  = 2'd1,
        DS_FIX_CHECK = 2'd2,
        DS_UNCORR    = 2'd3
    } dec_state_e;

    // Condensed view of the failing checks
    typedef struct packed {
        logic row_none;
        logic row_one;
        logic col_none;
        logic col_one;
        logic all_bad;
    } fail_sum_t;

    function automatic logic state_is_corrected(dec_state_e s);
        return (s == DS_FIX_DATA) || (s == DS_FIX_CHECK);
    endfunction

    function automatic logic state_is_uncorr(dec_state_e s);
        return s == DS_UNCORR;
    endfunction

endpackage

// File: rtl/pg_parity_gen.sv
module pg_parity_gen #(
    parameter int SIDE = 4,
    localparam int K = SIDE * SIDE
) (
    input  logic [K-1:0]    data,
    output logic [SIDE-1:0] row_par,
    output logic [SIDE-1:0] col_par,
    output logic            all_par
);
    // Rows are contiguous slices of the data word
    for (genvar r = 0; r < SIDE; r++) begin : g_row
        assign row_par[r] = ^data[r*SIDE +: SIDE];
    end

    // Columns gather one bit from each row
    for (genvar c = 0; c < SIDE; c++) begin : g_col
        logic [SIDE-1:0] cbits;
        for (genvar r = 0; r < SIDE; r++) begin : g_pick
            assign cbits[r] = data[r*SIDE + c];
        end
        assign col_par[c] = ^cbits;
    end

    assign all_par = ^data;
endmodule

// File: rtl/pg_syndrome.sv
module pg_syndrome #(
    parameter int SIDE = 4,
    localparam int K = SIDE * SIDE
) (
    input  logic [K-1:0]    rx_data,
    input  logic [SIDE-1:0] rx_row,
    input  logic [SIDE-1:0] rx_col,
    input  logic            rx_all,
    output logic [SIDE-1:0] row_fail,
    output logic [SIDE-1:0] col_fail,
    output logic            all_fail
);
    logic [SIDE-1:0] gen_row;
    logic [SIDE-1:0] gen_col;
    logic            gen_all;

    pg_parity_gen #(.SIDE(SIDE)) u_regen (
        .data    (rx_data),
        .row_par (gen_row),
        .col_par (gen_col),
        .all_par (gen_all)
    );

    assign row_fail = gen_row ^ rx_row;
    assign col_fail = gen_col ^ rx_col;
    // Whole-codeword parity: every received bit must XOR to zero
    assign all_fail = gen_all ^ (^rx_row) ^ (^rx_col) ^ rx_all;
endmodule

// File: rtl/pg_corrector.sv
module pg_corrector
    import pgrid_pkg::*;
#(
    parameter int SIDE = 4,
    localparam int K = SIDE * SIDE
) (
    input  logic [K-1:0]    rx_data,
    input  logic [SIDE-1:0] row_fail,
    input  logic [SIDE-1:0] col_fail,
    input  logic            all_fail,
    output logic [K-1:0]    fixed_data,
    output dec_state_e      state
);
    fail_sum_t       fs;
    logic [K-1:0]    flip_mask;

    assign fs.row_none = (row_fail == '0);
    assign fs.row_one  = $onehot(row_fail);
    assign fs.col_none = (col_fail == '0);
    assign fs.col_one  = $onehot(col_fail);
    assign fs.all_bad  = all_fail;

    // Crossing point of the failing row and failing column
    for (genvar r = 0; r < SIDE; r++) begin : g_mr
        for (genvar c = 0; c < SIDE; c++) begin : g_mc
            assign flip_mask[r*SIDE + c] = row_fail[r] & col_fail[c];
        end
    end

    always_comb begin
        if (fs.row_none && fs.col_none) begin
            state = fs.all_bad ? DS_FIX_CHECK : DS_CLEAN;
        end else if (fs.row_one && fs.col_one && fs.all_bad) begin
            state = DS_FIX_DATA;
        end else if (fs.all_bad &&
                     ((fs.row_one && fs.col_none) || (fs.row_none && fs.col_one))) begin
            state = DS_FIX_CHECK;
        end else begin
            state = DS_UNCORR;
        end
    end

    assign fixed_data = (state == DS_FIX_DATA) ? (rx_data ^ flip_mask) : rx_data;
endmodule

// File: rtl/parity_grid_codec.sv
module parity_grid_codec
    import pgrid_pkg::*;
#(
    parameter int SIDE = 4,
    parameter bit OUT_REG = 1'b1,
    localparam int K = SIDE * SIDE
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [K-1:0]    enc_data,
    output logic [SIDE-1:0] enc_row,
    output logic [SIDE-1:0] enc_col,
    output logic            enc_all,
    input  logic            dec_in_valid,
    input  logic [K-1:0]    dec_data,
    input  logic [SIDE-1:0] dec_row,
    input  logic [SIDE-1:0] dec_col,
    input  logic            dec_all,
    output logic            dec_out_valid,
    output logic [K-1:0]    dec_out_data,
    output logic            dec_corrected,
    output logic            dec_uncorrectable
);
    // ---------------- encoder ----------------
    pg_parity_gen #(.SIDE(SIDE)) u_enc (
        .data    (enc_data),
        .row_par (enc_row),
        .col_par (enc_col),
        .all_par (enc_all)
    );

    // R3
    enc_all_rows_chk: assert property (@(posedge clk) disable iff (rst)
        enc_all == (^enc_row));
    // R3
    enc_all_cols_chk: assert property (@(posedge clk) disable iff (rst)
        enc_all == (^enc_col));

    // ---------------- decoder ----------------
    logic [SIDE-1:0] row_fail;
    logic [SIDE-1:0] col_fail;
    logic            all_fail;
    logic [K-1:0]    fixed_data;
    dec_state_e      state;
    logic            corr_c;
    logic            unc_c;

    pg_syndrome #(.SIDE(SIDE)) u_syn (
        .rx_data  (dec_data),
        .rx_row   (dec_row),
        .rx_col   (dec_col),
        .rx_all   (dec_all),
        .row_fail (row_fail),
        .col_fail (col_fail),
        .all_fail (all_fail)
    );

    pg_corrector #(.SIDE(SIDE)) u_cor (
        .rx_data    (dec_data),
        .row_fail   (row_fail),
        .col_fail   (col_fail),
        .all_fail   (all_fail),
        .fixed_data (fixed_data),
        .state      (state)
    );

    assign corr_c = state_is_corrected(state);
    assign unc_c  = state_is_uncorr(state);

    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(dec_corrected && dec_uncorrectable));

    // ---------------- output stage ----------------
    if (OUT_REG) begin : g_reg
        logic         v_q;
        logic [K-1:0] d_q;
        logic         c_q;
        logic         u_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= '0;
                c_q <= 1'b0;
                u_q <= 1'b0;
            end else begin
                v_q <= dec_in_valid;
                if (dec_in_valid) begin
                    d_q <= fixed_data;
                    c_q <= corr_c;
                    u_q <= unc_c;
                end
            end
        end

        assign dec_out_valid     = v_q;
        assign dec_out_data      = d_q;
        assign dec_corrected     = c_q;
        assign dec_uncorrectable = u_q;

        // R9
        valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
            dec_in_valid |=> dec_out_valid);
        // R9
        valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
            !dec_in_valid |=> !dec_out_valid);
        // R7
        uncorr_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (dec_in_valid && (row_fail != '0) && (col_fail != '0) && !all_fail)
            |=> (dec_uncorrectable && (dec_out_data == $past(dec_data))));
        // R5
        one_bit_fix_chk: assert property (@(posedge clk) disable iff (rst)
            (dec_in_valid && $onehot(row_fail) && $onehot(col_fail) && all_fail)
            |=> (dec_corrected && ($countones(dec_out_data ^ $past(dec_data)) == 1)));
        // R4
        clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
            (dec_in_valid && (row_fail == '0) && (col_fail == '0) && !all_fail)
            |=> (!dec_corrected && !dec_uncorrectable && (dec_out_data == $past(dec_data))));
    end else begin : g_comb
        assign dec_out_valid     = dec_in_valid;
        assign dec_out_data      = fixed_data;
        assign dec_corrected     = corr_c;
        assign dec_uncorrectable = unc_c;

        // R4
        clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
            (dec_in_valid && (row_fail == '0) && (col_fail == '0) && !all_fail)
            |-> (!dec_corrected && !dec_uncorrectable && (dec_out_data == dec_data)));
        // R5
        one_bit_fix_chk: assert property (@(posedge clk) disable iff (rst)
            (dec_in_valid && $onehot(row_fail) && $onehot(col_fail) && all_fail)
            |-> ($countones(dec_out_data ^ dec_data) == 1));
    end
endmodule

// File: tb/sim_parity_grid_codec.sv
module sim_parity_grid_codec;
    localparam int SIDE = 4;
    localparam int K = SIDE * SIDE;
    localparam int N = K + 2*SIDE + 1;
    localparam time CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [K-1:0]    enc_data = '0;
    logic [SIDE-1:0] enc_row;
    logic [SIDE-1:0] enc_col;
    logic            enc_all;
    logic            dec_in_valid = 1'b0;
    logic [K-1:0]    dec_data = '0;
    logic [SIDE-1:0] dec_row = '0;
    logic [SIDE-1:0] dec_col = '0;
    logic            dec_all = 1'b0;
    logic            dec_out_valid;
    logic [K-1:0]    dec_out_data;
    logic            dec_corrected;
    logic            dec_uncorrectable;

    int n_checks = 0;
    int n_fails  = 0;

    logic [K-1:0] exp_d_q[$];
    bit           exp_c_q[$];
    bit           exp_u_q[$];
    string        tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    parity_grid_codec #(.SIDE(SIDE)) u0 (
        .clk               (clk),
        .rst               (rst),
        .enc_data          (enc_data),
        .enc_row           (enc_row),
        .enc_col           (enc_col),
        .enc_all           (enc_all),
        .dec_in_valid      (dec_in_valid),
        .dec_data          (dec_data),
        .dec_row           (dec_row),
        .dec_col           (dec_col),
        .dec_all           (dec_all),
        .dec_out_valid     (dec_out_valid),
        .dec_out_data      (dec_out_data),
        .dec_corrected     (dec_corrected),
        .dec_uncorrectable (dec_uncorrectable)
    );

    // Bench reference parities, written from R1..R3
    function automatic logic [SIDE-1:0] ref_rows(logic [K-1:0] d);
        logic [SIDE-1:0] v = '0;
        for (int r = 0; r < SIDE; r++)
            for (int c = 0; c < SIDE; c++)
                v[r] = v[r] ^ d[r*SIDE + c];
        return v;
    endfunction

    function automatic logic [SIDE-1:0] ref_cols(logic [K-1:0] d);
        logic [SIDE-1:0] v = '0;
        for (int c = 0; c < SIDE; c++)
            for (int r = 0; r < SIDE; r++)
                v[c] = v[c] ^ d[r*SIDE + c];
        return v;
    endfunction

    function automatic logic [N-1:0] ref_codeword(logic [K-1:0] d);
        logic [SIDE-1:0] rw = ref_rows(d);
        logic [SIDE-1:0] cl = ref_cols(d);
        logic            al = (^d) ^ (^rw) ^ (^cl);
        return {al, cl, rw, d};
    endfunction

    task automatic check(string req, string what, logic [K-1:0] act, logic [K-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic enc_test(logic [K-1:0] d);
        logic [N-1:0] cw;
        enc_data = d;
        #1;
        cw = ref_codeword(d);
        check("R1", "enc_row", K'(enc_row), K'(cw[K +: SIDE]));
        check("R2", "enc_col", K'(enc_col), K'(cw[K+SIDE +: SIDE]));
        check("R3", "enc_all", K'(enc_all), K'(cw[N-1]));
    endtask

    // Driver: one codeword per falling edge, expectation queued
    task automatic send(logic [K-1:0] d, logic [N-1:0] emask, string tag);
        logic [N-1:0] rx;
        int ne;
        @(negedge clk);
        rx = ref_codeword(d) ^ emask;
        ne = $countones(emask);
        dec_in_valid = 1'b1;
        dec_data = rx[K-1:0];
        dec_row  = rx[K +: SIDE];
        dec_col  = rx[K+SIDE +: SIDE];
        dec_all  = rx[N-1];
        if (ne == 0) begin
            exp_d_q.push_back(d); exp_c_q.push_back(1'b0); exp_u_q.push_back(1'b0);
        end else if (ne == 1) begin
            exp_d_q.push_back(d); exp_c_q.push_back(1'b1); exp_u_q.push_back(1'b0);
        end else begin
            exp_d_q.push_back(rx[K-1:0]); exp_c_q.push_back(1'b0); exp_u_q.push_back(1'b1);
        end
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        dec_in_valid = 1'b0;
    endtask

    // Monitor: pops one expectation for every valid result
    always @(negedge clk) begin
        if (!rst && dec_out_valid) begin
            if (exp_d_q.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R9 unexpected valid actual=1 expected=0");
            end else begin
                logic [K-1:0] ed;
                bit ec, eu;
                string tg;
                ed = exp_d_q.pop_front();
                ec = exp_c_q.pop_front();
                eu = exp_u_q.pop_front();
                tg = tag_q.pop_front();
                check(tg, "data", dec_out_data, ed);
                check(tg, "corrected", K'(dec_corrected), K'(ec));
                check(tg, "uncorrectable", K'(dec_uncorrectable), K'(eu));
                // R8
                check("R8", "flag overlap", K'(dec_corrected & dec_uncorrectable), '0);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [K-1:0] words [4];
        words[0] = 16'h0000; words[1] = 16'hFFFF;
        words[2] = 16'hA5C3; words[3] = 16'h1E70;

        // Reset state, R9
        repeat (2) @(negedge clk);
        check("R9", "valid in reset", K'(dec_out_valid), '0);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "valid after reset", K'(dec_out_valid), '0);

        // Encoder: R1 R2 R3
        for (int i = 0; i < 4; i++) enc_test(words[i]);
        for (int i = 0; i < K; i++) enc_test(K'(1) << i);
        enc_test(16'h8421);

        // Latency probe, R9
        idle();
        @(negedge clk);
        dec_in_valid = 1'b1;
        dec_data = words[2]; dec_row = ref_rows(words[2]);
        dec_col = ref_cols(words[2]); dec_all = ref_codeword(words[2])[N-1];
        exp_d_q.push_back(words[2]); exp_c_q.push_back(1'b0);
        exp_u_q.push_back(1'b0); tag_q.push_back("R9");
        #1;
        check("R9", "valid too early", K'(dec_out_valid), '0);
        idle();

        // Clean words, R4
        for (int i = 0; i < 4; i++) send(words[i], '0, "R4");
        send(16'h3C3C, '0, "R4");

        // Single data errors, R5
        for (int w = 1; w < 4; w++)
            for (int b = 0; b < K; b++)
                send(words[w], N'(1) << b, "R5");

        // Single check-bit errors, R6
        for (int w = 0; w < 4; w++)
            for (int b = K; b < N; b++)
                send(words[w], N'(1) << b, "R6");

        // Every double error on one word, R7
        for (int i = 0; i < N; i++)
            for (int j = i + 1; j < N; j++)
                send(words[2], (N'(1) << i) | (N'(1) << j), "R7");
        send(words[3], N'(3), "R7");
        send(words[1], (N'(1) << 5) | (N'(1) << (N-1)), "R7");

        idle();
        repeat (3) @(negedge clk);
        check("R9", "results outstanding", K'(exp_d_q.size()), '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule